// File: doc/BRIEF.md
# Memory Protection Region Descriptor

This block is a single region entry of a bus memory protection unit. Software programs it through a small register bus. It holds four 32-bit descriptor words: region start, region end, an access-control word and a process-ID word. A valid flag sits beside them. A second register address aliases the access-control word, so software can change permissions while a task switch is in progress without disturbing validity. Any write to the start, end or access-control word through its own address drops the valid flag, so a descriptor that is half rewritten never matches.

In parallel, the block evaluates one bus access per cycle. Each access carries a master number, an address, an access kind (read, write or instruction fetch), a supervisor/user flag and a process ID. One cycle later the block reports whether the access falls in the region and, if it does, whether it is granted or must end in an access error. Masters 4 to 7 carry only read and write enables. Masters 0 to 3 carry a supervisor mode, user read/write/execute rights and an optional masked process-ID match. An access that misses produces neither grant nor error; merging several descriptors is left to the enclosing unit.

Top module: `mpu_region_desc`

## Requirements
- R1: After reset the valid flag, start, end, access-control and process-ID words are all zero. Every descriptor word and the alias read back 0, and no access hits.
- R2: A write to word 0 (`DESC_BASE+16*REGION_ID`), word 1 (`+4`) or word 2 (`+8`) clears the valid flag. While nothing is written, the flag holds its value.
- R3: A write to word 3 (`+12`) loads the valid flag from data bit 0, the process ID from data bits [31:24] and the process-ID mask from bits [23:16]. Word 3 reads back those fields in the same places, with every other bit zero.
- R4: A write to the alias address `ALIAS_BASE+4*REGION_ID` updates the access-control word and leaves the valid flag unchanged. The alias and word 2 always read back the same value.
- R5: Word 0 holds the start address and word 1 the end address, both in bits [31:5], and bits [4:0] read back as 0. An access hits when the valid flag is set and start*32 <= address <= end*32+31.
- R6: An access that does not hit raises neither grant nor error.
- R7: For a master m in 4..7, its read enable sits at bit 25+2*(m-4) of the access-control word and its write enable at bit 24+2*(m-4). A read or fetch needs the read enable and a write needs the write enable; otherwise a hitting access ends in an error.
- R8: For a master m in 0..3, bits [6m+5:6m] of the access-control word hold, from the top bit down: process enable, a 2-bit supervisor mode, user read, user write and user execute. A user access is allowed exactly when the matching user right is set.
- R9: A supervisor access from masters 0..3 follows its supervisor mode. 00 allows read, write and execute. 01 allows read and execute. 10 allows read and write. 11 uses the user rights.
- R10: When the requesting master's process enable is set, a hit also requires ((access PID XOR stored PID) AND NOT mask) == 0. With the enable clear, the process ID has no effect.
- R11: The access kind is encoded 00 read, 01 write and 1x fetch. An access presented in one cycle produces `res_valid` with its hit, grant and error in the next cycle. A hit always raises exactly one of grant or error.
- R12: A register read returns its data on `reg_rdata` one cycle after `reg_re`. Unmapped addresses, including unaligned ones, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_master | input | 3 | Requesting master number |
| acc_addr | input | ADDR_W | Access byte address |
| acc_kind | input | 2 | 00 read, 01 write, 1x fetch |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_pid | input | 8 | Process ID of the access |
| res_valid | output | 1 | Verdict valid for the previous cycle's access |
| res_hit | output | 1 | Access falls in this region |
| res_grant | output | 1 | Access hit and is permitted |
| res_err | output | 1 | Access hit and must end in an access error |

## Verification
The assertions watch on every cycle the effect of register writes on the valid flag: words 0 to 2 clear it, word 3 loads it from bit 0, the alias keeps it, and silence holds it. They also watch the shape of the verdict: one-cycle response, grant and error exclusive and only with a hit, and no hit while invalid. Only the bench scenarios can show whether a given grant is the right one. That covers the address bounds at the granule edges, each master's bit positions, the four supervisor modes, fetch versus read, the masked process-ID compare, and the readback values of every word, the alias and unmapped addresses.

// File: rtl/rgd_pkg.sv
package rgd_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NUM_MASTERS = 8;
  localparam int unsigned NUM_FULL    = 4;
  localparam int unsigned MSTR_W      = $clog2(NUM_MASTERS);
  localparam int unsigned FIELD_W     = 6;
  localparam int unsigned ID_W        = 8;
  localparam int unsigned SIMPLE_LSB  = NUM_FULL * FIELD_W;
  localparam int unsigned NWORDS      = 4;

  // supervisor mode of a full master field
  typedef enum logic [1:0] {
    SM_RWX  = 2'b00,
    SM_RX   = 2'b01,
    SM_RW   = 2'b10,
    SM_USER = 2'b11
  } sup_mode_e;

  // full master field, top bit first
  typedef struct packed {
    logic      pid_en;
    sup_mode_e smode;
    logic      u_rd;
    logic      u_wr;
    logic      u_ex;
  } full_ctl_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  typedef enum logic [1:0] {
    ACC_RD    = 2'b00,
    ACC_WR    = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_FALT  = 2'b11
  } acc_kind_e;

  function automatic rights_t sup_rights(full_ctl_t c);
    rights_t r;
    case (c.smode)
      SM_RWX:  r = 3'b111;
      SM_RX:   r = 3'b101;
      SM_RW:   r = 3'b110;
      default: r = {c.u_rd, c.u_wr, c.u_ex};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rgd_regs.sv
module rgd_regs
  import rgd_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned GRAN_W     = 5,
  parameter int unsigned DESC_BASE  = 32'h400,
  parameter int unsigned ALIAS_BASE = 32'h800,
  parameter int unsigned REGION_ID  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  output logic [ADDR_W-GRAN_W-1:0] start_q,
  output logic [ADDR_W-GRAN_W-1:0] limit_q,
  output logic [WORD_W-1:0]        acl_q,
  output logic [ID_W-1:0]          pid_q,
  output logic [ID_W-1:0]          pmask_q,
  output logic                     valid_q
);

  localparam int unsigned STRIDE   = NWORDS * 4;
  localparam int unsigned FIRST    = DESC_BASE + STRIDE * REGION_ID;
  localparam int unsigned PID_LSB  = WORD_W - ID_W;
  localparam int unsigned MASK_LSB = WORD_W - 2 * ID_W;

  logic [NWORDS-1:0] sel_w;
  logic              sel_alias;
  logic [WORD_W-1:0] rd_word;

  for (genvar w = 0; w < NWORDS; w++) begin : g_dec
    assign sel_w[w] = (reg_addr == REG_AW'(FIRST + 4 * w));
  end
  assign sel_alias = (reg_addr == REG_AW'(ALIAS_BASE + 4 * REGION_ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      limit_q <= '0;
      acl_q   <= '0;
      pid_q   <= '0;
      pmask_q <= '0;
      valid_q <= 1'b0;
    end else if (reg_we) begin
      if (sel_w[0]) begin
        start_q <= reg_wdata[ADDR_W-1:GRAN_W];
        valid_q <= 1'b0;
      end
      if (sel_w[1]) begin
        limit_q <= reg_wdata[ADDR_W-1:GRAN_W];
        valid_q <= 1'b0;
      end
      if (sel_w[2] || sel_alias) acl_q <= reg_wdata;
      if (sel_w[2]) valid_q <= 1'b0;
      if (sel_w[3]) begin
        pid_q   <= reg_wdata[PID_LSB +: ID_W];
        pmask_q <= reg_wdata[MASK_LSB +: ID_W];
        valid_q <= reg_wdata[0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel_w[0]) rd_word = WORD_W'({start_q, {GRAN_W{1'b0}}});
    if (sel_w[1]) rd_word = WORD_W'({limit_q, {GRAN_W{1'b0}}});
    if (sel_w[2] || sel_alias) rd_word = acl_q;
    if (sel_w[3]) begin
      rd_word[PID_LSB +: ID_W]  = pid_q;
      rd_word[MASK_LSB +: ID_W] = pmask_q;
      rd_word[0]                = valid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_word;
  end

endmodule

// File: rtl/rgd_perm.sv
module rgd_perm
  import rgd_pkg::*;
(
  input  logic [WORD_W-1:0] acl,
  input  logic [MSTR_W-1:0] acc_master,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  output logic              allow,
  output logic              pid_chk
);

  rights_t                rts [NUM_MASTERS];
  logic [NUM_MASTERS-1:0] pe_v;
  rights_t                sel;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
    if (m < NUM_FULL) begin : g_full
      full_ctl_t c;
      rights_t   usr;
      assign c      = full_ctl_t'(acl[m*FIELD_W +: FIELD_W]);
      assign usr    = {c.u_rd, c.u_wr, c.u_ex};
      assign rts[m] = acc_super ? sup_rights(c) : usr;
      assign pe_v[m] = c.pid_en;
    end else begin : g_simple
      localparam int unsigned B = SIMPLE_LSB + 2 * (m - NUM_FULL);
      // fetch shares the read enable
      assign rts[m]  = {acl[B+1], acl[B], acl[B+1]};
      assign pe_v[m] = 1'b0;
    end
  end

  assign sel     = rts[acc_master];
  assign pid_chk = pe_v[acc_master];

  always_comb begin
    case (acc_kind_e'(acc_kind))
      ACC_RD:  allow = sel.rd;
      ACC_WR:  allow = sel.wr;
      default: allow = sel.ex;
    endcase
  end

endmodule

// File: rtl/rgd_eval.sv
module rgd_eval
  import rgd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned GRAN_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [ID_W-1:0]          acc_pid,
  input  logic [ADDR_W-GRAN_W-1:0] start_q,
  input  logic [ADDR_W-GRAN_W-1:0] limit_q,
  input  logic                     valid_q,
  input  logic [ID_W-1:0]          pid_q,
  input  logic [ID_W-1:0]          pmask_q,
  input  logic                     allow,
  input  logic                     pid_chk,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic                     res_grant,
  output logic                     res_err
);

  logic lo_ok, hi_ok, pid_ok, hit_c;

  assign lo_ok  = acc_addr >= {start_q, {GRAN_W{1'b0}}};
  assign hi_ok  = acc_addr <= {limit_q, {GRAN_W{1'b1}}};
  assign pid_ok = !pid_chk || (((acc_pid ^ pid_q) & ~pmask_q) == '0);
  assign hit_c  = acc_valid && valid_q && lo_ok && hi_ok && pid_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_grant <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      res_hit   <= hit_c;
      res_grant <= hit_c && allow;
      res_err   <= hit_c && !allow;
    end
  end

endmodule

// File: rtl/mpu_region_desc.sv
module mpu_region_desc
  import rgd_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned GRAN_W     = 5,
  parameter int unsigned DESC_BASE  = 32'h400,
  parameter int unsigned ALIAS_BASE = 32'h800,
  parameter int unsigned REGION_ID  = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  input  logic                  acc_valid,
  input  logic [MSTR_W-1:0]     acc_master,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [1:0]            acc_kind,
  input  logic                  acc_super,
  input  logic [ID_W-1:0]       acc_pid,
  output logic                  res_valid,
  output logic                  res_hit,
  output logic                  res_grant,
  output logic                  res_err
);

  logic [ADDR_W-GRAN_W-1:0] start_q, limit_q;
  logic [WORD_W-1:0]        acl_q;
  logic [ID_W-1:0]          pid_q, pmask_q;
  logic                     desc_valid;
  logic                     allow, pid_chk;

  rgd_regs #(
    .REG_AW(REG_AW), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
    .DESC_BASE(DESC_BASE), .ALIAS_BASE(ALIAS_BASE), .REGION_ID(REGION_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_q(start_q), .limit_q(limit_q), .acl_q(acl_q),
    .pid_q(pid_q), .pmask_q(pmask_q), .valid_q(desc_valid)
  );

  rgd_perm u_perm (
    .acl(acl_q), .acc_master(acc_master), .acc_kind(acc_kind),
    .acc_super(acc_super), .allow(allow), .pid_chk(pid_chk)
  );

  rgd_eval #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_eval (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_pid(acc_pid), .start_q(start_q), .limit_q(limit_q),
    .valid_q(desc_valid), .pid_q(pid_q), .pmask_q(pmask_q),
    .allow(allow), .pid_chk(pid_chk),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_grant(res_grant), .res_err(res_err)
  );

endmodule

// File: rtl/rgd_checker.sv
module rgd_checker #(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned DESC_BASE  = 32'h400,
  parameter int unsigned ALIAS_BASE = 32'h800,
  parameter int unsigned REGION_ID  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              acc_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_grant,
  input logic              res_err,
  input logic              desc_valid
);

  localparam int unsigned FIRST = DESC_BASE + 16 * REGION_ID;

  logic wr_clr, wr_w3, wr_alias;
  assign wr_clr   = reg_we && (reg_addr == REG_AW'(FIRST) ||
                               reg_addr == REG_AW'(FIRST + 4) ||
                               reg_addr == REG_AW'(FIRST + 8));
  assign wr_w3    = reg_we && reg_addr == REG_AW'(FIRST + 12);
  assign wr_alias = reg_we && reg_addr == REG_AW'(ALIAS_BASE + 4 * REGION_ID);

  p_clear_on_word_r2: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> !desc_valid);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(desc_valid));
  p_load_word3_r3: assert property (@(posedge clk) disable iff (rst)
    wr_w3 |=> desc_valid == $past(reg_wdata[0]));
  p_alias_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    wr_alias |=> desc_valid == $past(desc_valid));
  p_invalid_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !desc_valid && !reg_we) |=> !res_hit);
  p_verdict_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (res_grant || res_err) |-> res_hit);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> $onehot({res_grant, res_err}));
  p_resp_next_r11: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);
  p_no_resp_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid && !res_hit);

endmodule

bind mpu_region_desc rgd_checker #(
  .REG_AW(REG_AW), .DESC_BASE(DESC_BASE),
  .ALIAS_BASE(ALIAS_BASE), .REGION_ID(REGION_ID)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_grant(res_grant), .res_err(res_err),
  .desc_valid(desc_valid)
);

// File: tb/sim_mpu_region_desc.sv
module sim_mpu_region_desc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_master = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_super = 1'b0;
  logic [7:0]  acc_pid = '0;
  logic        res_valid, res_hit, res_grant, res_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [11:0] W0 = 12'h400, W1 = 12'h404, W2 = 12'h408,
                          W3 = 12'h40C, AL = 12'h800;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10;
  localparam logic [31:0] ALL = 32'hFF1C71C7;

  always #5 clk = ~clk;

  mpu_region_desc u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_master(acc_master), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_super(acc_super), .acc_pid(acc_pid),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_grant(res_grant), .res_err(res_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(logic pe, logic [1:0] sm, logic r,
                                      logic w, logic x, int m);
    return 32'({pe, sm, r, w, x}) << (6 * m);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  // verdict checked as {res_valid, hit, grant, err}
  task automatic acc(string req, int m, logic [31:0] a, logic [1:0] k,
                     logic sup, logic [7:0] pid, logic eh, logic eg, logic ee);
    @(negedge clk);
    acc_valid = 1'b1; acc_master = 3'(m); acc_addr = a;
    acc_kind = k; acc_super = sup; acc_pid = pid;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {28'd0, res_valid, res_hit, res_grant, res_err},
          {28'd0, 1'b1, eh, eg, ee});
  endtask

  task automatic t_reset;
    rd_chk("R1 word0", W0, 32'h0);
    rd_chk("R1 word1", W1, 32'h0);
    rd_chk("R1 word2", W2, 32'h0);
    rd_chk("R1 word3", W3, 32'h0);
    rd_chk("R1 alias", AL, 32'h0);
    acc("R1 no hit after reset", 0, 32'h0, RD, 1'b1, 8'h0, 0, 0, 0);
  endtask

  task automatic t_range;
    wr(W0, 32'h0000101F);
    wr(W1, 32'h00001FE0);
    wr(W2, ALL);
    wr(W3, 32'h00000001);
    rd_chk("R5 start low bits read 0", W0, 32'h00001000);
    acc("R5 below start", 0, 32'h00000FFF, RD, 1'b0, 8'h0, 0, 0, 0);
    acc("R5 first byte", 0, 32'h00001000, RD, 1'b0, 8'h0, 1, 1, 0);
    acc("R5 last byte of end granule", 0, 32'h00001FFF, RD, 1'b0, 8'h0, 1, 1, 0);
    acc("R6 above end", 0, 32'h00002000, WR, 1'b0, 8'h0, 0, 0, 0);
    @(negedge clk);
    check("R11 idle gives no verdict", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_word3;
    wr(W3, 32'hA50F00FE);
    rd_chk("R3 word3 readback", W3, 32'hA50F0000);
    acc("R3 valid cleared by bit0=0", 0, 32'h1000, RD, 1'b0, 8'h0, 0, 0, 0);
    wr(W3, 32'h00000001);
    rd_chk("R3 word3 valid set", W3, 32'h00000001);
    acc("R3 valid set hits", 0, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
  endtask

  task automatic t_clear;
    wr(W0, 32'h00001000);
    acc("R2 word0 write clears", 0, 32'h1000, RD, 1'b0, 8'h0, 0, 0, 0);
    wr(W3, 32'h1);
    wr(W1, 32'h00001FE0);
    acc("R2 word1 write clears", 0, 32'h1000, RD, 1'b0, 8'h0, 0, 0, 0);
    wr(W3, 32'h1);
    wr(W2, ALL);
    acc("R2 word2 write clears", 0, 32'h1000, RD, 1'b0, 8'h0, 0, 0, 0);
    wr(W3, 32'h1);
    acc("R2 revalidated", 0, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
  endtask

  task automatic t_alias;
    wr(AL, 32'hFF1C71C5);
    acc("R4 alias keeps valid", 0, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
    acc("R4 alias new perms", 0, 32'h1000, WR, 1'b0, 8'h0, 1, 0, 1);
    rd_chk("R4 word2 mirrors alias", W2, 32'hFF1C71C5);
    rd_chk("R4 alias readback", AL, 32'hFF1C71C5);
  endtask

  task automatic t_simple;
    wr(AL, 32'h18000000);
    acc("R7 m5 read", 5, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
    acc("R7 m5 write", 5, 32'h1000, WR, 1'b1, 8'h0, 1, 0, 1);
    acc("R7 m5 fetch", 5, 32'h1000, FE, 1'b0, 8'h0, 1, 1, 0);
    acc("R7 m6 write", 6, 32'h1000, WR, 1'b0, 8'h0, 1, 1, 0);
    acc("R7 m6 read", 6, 32'h1000, RD, 1'b0, 8'h0, 1, 0, 1);
    acc("R7 m7 read", 7, 32'h1000, RD, 1'b0, 8'h0, 1, 0, 1);
    acc("R7 m4 write", 4, 32'h1000, WR, 1'b0, 8'h0, 1, 0, 1);
  endtask

  task automatic t_user;
    wr(AL, fld(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 2));
    acc("R8 m2 user read", 2, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
    acc("R8 m2 user write", 2, 32'h1000, WR, 1'b0, 8'h0, 1, 0, 1);
    acc("R8 m2 user fetch", 2, 32'h1000, 2'b11, 1'b0, 8'h0, 1, 1, 0);
    acc("R9 mode11 sup read", 2, 32'h1000, RD, 1'b1, 8'h0, 1, 1, 0);
    acc("R9 mode11 sup write", 2, 32'h1000, WR, 1'b1, 8'h0, 1, 0, 1);
  endtask

  task automatic t_super;
    wr(AL, fld(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1));
    acc("R9 mode01 sup read", 1, 32'h1000, RD, 1'b1, 8'h0, 1, 1, 0);
    acc("R9 mode01 sup write", 1, 32'h1000, WR, 1'b1, 8'h0, 1, 0, 1);
    acc("R9 mode01 sup fetch", 1, 32'h1000, FE, 1'b1, 8'h0, 1, 1, 0);
    acc("R8 m1 user no rights", 1, 32'h1000, RD, 1'b0, 8'h0, 1, 0, 1);
    wr(AL, fld(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1));
    acc("R9 mode10 sup write", 1, 32'h1000, WR, 1'b1, 8'h0, 1, 1, 0);
    acc("R9 mode10 sup fetch", 1, 32'h1000, FE, 1'b1, 8'h0, 1, 0, 1);
    wr(AL, 32'h0);
    acc("R9 mode00 sup write", 1, 32'h1000, WR, 1'b1, 8'h0, 1, 1, 0);
    acc("R9 mode00 sup fetch", 1, 32'h1000, FE, 1'b1, 8'h0, 1, 1, 0);
  endtask

  task automatic t_pid;
    wr(W3, 32'hA50F0001);
    wr(AL, fld(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 0));
    acc("R10 masked low nibble", 0, 32'h1000, RD, 1'b0, 8'hA0, 1, 1, 0);
    acc("R10 exact pid", 0, 32'h1000, RD, 1'b0, 8'hA5, 1, 1, 0);
    acc("R10 upper mismatch", 0, 32'h1000, RD, 1'b0, 8'hB5, 0, 0, 0);
    acc("R10 other master ignores pid", 1, 32'h1000, RD, 1'b0, 8'hB5, 1, 0, 1);
    wr(AL, fld(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 0));
    acc("R10 enable clear ignores pid", 0, 32'h1000, RD, 1'b0, 8'hB5, 1, 1, 0);
  endtask

  task automatic t_unmapped;
    rd_chk("R12 unmapped read", 12'h004, 32'h0);
    wr(12'h410, 32'hFFFFFFFF);
    wr(12'h401, 32'hFFFFFFFF);
    rd_chk("R12 word0 untouched", W0, 32'h00001000);
    rd_chk("R12 word2 untouched", W2, fld(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 0));
    acc("R12 valid untouched", 0, 32'h1000, RD, 1'b0, 8'h0, 1, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_range();
    t_word3();
    t_clear();
    t_alias();
    t_simple();
    t_user();
    t_super();
    t_pid();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule